// File: doc/BRIEF.md
# Eight-Channel RS(255,239) Systematic Encoder

This block computes a systematic Reed-Solomon RS(255,239) code over GF(2^8) for eight independent code channels that share one byte-wide datapath. Input symbols arrive channel-interleaved: symbol i of a group belongs to channel i mod 8. Each accepted symbol is qualified by a new-data strobe. A single one-cycle start pulse opens a group of eight code blocks, one per channel. The block forwards every information symbol one cycle after it is accepted. After the last information symbol of channel 7, it emits the 16 check symbols of each channel.

The eight shift-register states sit in a small memory that a 3-bit channel counter addresses. One GF(2^8) update network serves all channels in turn. A ready-for-data output falls for the 128 cycles of check output, so it can drive the read request of an upstream FIFO. A ready-for-first-data output is high whenever no group is open, so gating it with an enable yields the start pulse. A clock enable freezes the whole block.

Top module: `rs_enc_mc`

## Requirements
- R1: Each channel's 16 check symbols are the remainder of its 239 information symbols times x^16, divided by g(x) = (x+a^0)(x+a^1)...(x+a^15). Here a = 0x02 in the field generated by 0x11D, and the first information symbol is the highest-degree coefficient. Check symbols leave highest degree first.
- R2: Within a group, the i-th accepted symbol (counting from 0 at the start symbol) belongs to channel i mod 8 and to information position i div 8 of that channel.
- R3: An accepted information symbol appears on data_o with valid_o high on the cycle after the edge that accepts it, in input order.
- R4: After the 1912th accepted symbol, the next 128 enabled cycles each deliver one check symbol: check symbol p of channels 0..7 in channel order, then p+1.
- R5: With rffd_o high, a group opens only on an enabled edge where start_i and nd_i are both high, and that symbol is channel 0's first symbol. Without it, nothing is output. start_i while a group is open has no effect.
- R6: With nd_i low, no symbol is accepted and valid_o is low after that enabled edge. During check output, nd_i and data_i are ignored.
- R7: rfd_o is low exactly during check output, for 128 enabled cycles per group, and high otherwise.
- R8: rffd_o is high exactly while no group is open. A new group may open on the edge right after the last check symbol is emitted.
- R9: With ce_i low, no input is accepted and data_o, valid_o, rfd_o, rffd_o and all internal progress hold.
- R10: During and after reset, valid_o=0, data_o=0, rfd_o=1 and rffd_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Clock enable; low freezes the block |
| start_i | input | 1 | One-cycle pulse that opens a group of eight code blocks |
| nd_i | input | 1 | New-data strobe qualifying data_i |
| data_i | input | 8 | Channel-interleaved information symbol |
| data_o | output | 8 | Forwarded information symbol or check symbol |
| valid_o | output | 1 | data_o carries a new symbol |
| rfd_o | output | 1 | Ready for data; low during check output |
| rffd_o | output | 1 | Ready for the first symbol of a group |

## Verification
Random full-rate groups compare every output byte against a long-division model. This separates a correct generator polynomial and a correct output order from a transposed interleave. An impulse group places a distinct nonzero value only in the last information symbol of each channel, so each channel's check set is a scaled copy of the generator coefficients. Any mix-up between channel state slots shows up as a wrong channel. Groups with nd_i gaps, garbage on data_i during check output, and stray start pulses test that strobes are qualified correctly. Groups with random ce_i holes, followed by back-to-back groups opened the cycle rffd_o rises, test the freeze and the zero-gap hand-over between groups.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  typedef logic [SYM_W-1:0] sym_t;

  function automatic sym_t gf_mul(sym_t a, sym_t b, logic [SYM_W:0] poly);
    sym_t p = '0;
    sym_t x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ poly[SYM_W-1:0]) : (x << 1);
    end
    return p;
  endfunction
endpackage

// File: rtl/rs_enc_lfsr.sv
module rs_enc_lfsr
  import rs_enc_pkg::*;
#(
  parameter int NCHK = 16,
  parameter logic [SYM_W:0] POLY = 9'h11D
) (
  input  logic [NCHK-1:0][SYM_W-1:0] state_i,
  input  sym_t                       sym_i,
  output logic [NCHK-1:0][SYM_W-1:0] state_o
);
  // generator coefficients g0..g(NCHK-1), monic term implied
  function automatic logic [NCHK-1:0][SYM_W-1:0] gen_coef();
    logic [NCHK:0][SYM_W-1:0] g;
    sym_t root;
    g = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int i = 0; i < NCHK; i++) begin
      for (int j = NCHK; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root, POLY);
      g[0] = gf_mul(g[0], root, POLY);
      root = gf_mul(root, sym_t'(2), POLY);
    end
    return g[NCHK-1:0];
  endfunction

  localparam logic [NCHK-1:0][SYM_W-1:0] GEN = gen_coef();

  sym_t fb;
  assign fb = sym_i ^ state_i[NCHK-1];
  assign state_o[0] = gf_mul(fb, GEN[0], POLY);

  for (genvar j = 1; j < NCHK; j++) begin : g_tap
    assign state_o[j] = state_i[j-1] ^ gf_mul(fb, GEN[j], POLY);
  end
endmodule

// File: rtl/rs_enc_state_mem.sv
module rs_enc_state_mem #(
  parameter int DEPTH = 8,
  parameter int W     = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/rs_enc_seq.sv
module rs_enc_seq #(
  parameter int CHANNELS = 8,
  parameter int K        = 239,
  parameter int NCHK     = 16,
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int RND_W   = $clog2(K)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_i,
  input  logic            start_i,
  input  logic            nd_i,
  output logic [CH_W-1:0] ch_o,
  output logic            first_rnd_o,
  output logic            take_o,
  output logic            emit_o,
  output logic            busy_o,
  output logic            chk_o
);
  localparam logic [CH_W-1:0]  CH_LAST   = CH_W'(CHANNELS - 1);
  localparam logic [RND_W-1:0] INFO_LAST = RND_W'(K - 1);
  localparam logic [RND_W-1:0] CHK_LAST  = RND_W'(NCHK - 1);

  logic [CH_W-1:0]  ch_q;
  logic [RND_W-1:0] rnd_q;
  logic             busy_q, chk_q;

  assign take_o = ce_i & nd_i & ~chk_q & (busy_q | start_i);
  assign emit_o = ce_i & chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q   <= '0;
      rnd_q  <= '0;
      busy_q <= 1'b0;
      chk_q  <= 1'b0;
    end else if (take_o || emit_o) begin
      busy_q <= 1'b1;
      ch_q   <= (ch_q == CH_LAST) ? '0 : ch_q + 1'b1;
      if (ch_q == CH_LAST) begin
        if (take_o && rnd_q == INFO_LAST) begin
          rnd_q <= '0;
          chk_q <= 1'b1;
        end else if (emit_o && rnd_q == CHK_LAST) begin
          rnd_q  <= '0;
          chk_q  <= 1'b0;
          busy_q <= 1'b0;
        end else begin
          rnd_q <= rnd_q + 1'b1;
        end
      end
    end
  end

  assign ch_o        = ch_q;
  assign first_rnd_o = ~chk_q & (rnd_q == '0);
  assign busy_o      = busy_q;
  assign chk_o       = chk_q;
endmodule

// File: rtl/rs_enc_mc.sv
module rs_enc_mc
  import rs_enc_pkg::*;
#(
  parameter int N             = 255,
  parameter int K             = 239,
  parameter int CHANNELS      = 8,
  parameter logic [8:0] POLY  = 9'h11D
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       start_i,
  input  logic       nd_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       rfd_o,
  output logic       rffd_o
);
  localparam int NCHK      = N - K;
  localparam int ST_W      = NCHK * SYM_W;
  localparam int CH_W      = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam int TOTAL_CHK = NCHK * CHANNELS;

  logic [CH_W-1:0] ch;
  logic first_rnd, take, emit, busy, chk;

  rs_enc_seq #(.CHANNELS(CHANNELS), .K(K), .NCHK(NCHK)) i_seq (
    .clk_i, .rst_ni, .ce_i, .start_i, .nd_i,
    .ch_o(ch), .first_rnd_o(first_rnd), .take_o(take), .emit_o(emit),
    .busy_o(busy), .chk_o(chk)
  );

  logic [NCHK-1:0][SYM_W-1:0] rd_st, old_st, nxt_st, shf_st, wr_st;

  rs_enc_state_mem #(.DEPTH(CHANNELS), .W(ST_W)) i_mem (
    .clk_i, .we_i(take | emit), .addr_i(ch), .wdata_i(wr_st), .rdata_o(rd_st)
  );

  // first symbol of each channel starts from a cleared remainder
  assign old_st = first_rnd ? '0 : rd_st;

  rs_enc_lfsr #(.NCHK(NCHK), .POLY(POLY)) i_lfsr (
    .state_i(old_st), .sym_i(data_i), .state_o(nxt_st)
  );

  assign shf_st = {rd_st[NCHK-2:0], sym_t'(0)};
  assign wr_st  = take ? nxt_st : shf_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (ce_i) begin
      valid_o <= take | emit;
      if (take)      data_o <= data_i;
      else if (emit) data_o <= rd_st[NCHK-1];
    end
  end

  assign rfd_o  = ~chk;
  assign rffd_o = ~busy;
endmodule

// File: rtl/rs_enc_mc_chk.sv
module rs_enc_mc_chk #(
  parameter int TOTAL_CHK = 128
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_i,
  input logic       start_i,
  input logic       nd_i,
  input logic [7:0] data_i,
  input logic [7:0] data_o,
  input logic       valid_o,
  input logic       rfd_o,
  input logic       rffd_o
);
  int unsigned run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_len <= 0;
    else if (rfd_o)       run_len <= 0;
    else if (ce_i)        run_len <= run_len + 1;
  end

  a_r8_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rffd_o |-> rfd_o);

  a_r9_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(valid_o) && $stable(data_o) && $stable(rfd_o) && $stable(rffd_o));

  a_r4_check_emits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !rfd_o |=> valid_o);

  a_r5_no_start_no_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && rffd_o && !(start_i && nd_i) |=> !valid_o && rffd_o);

  a_r6_nd_low_no_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && rfd_o && !rffd_o && !nd_i |=> !valid_o);

  a_r3_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && rfd_o && nd_i && (start_i || !rffd_o) |=> valid_o && data_o == $past(data_i));

  a_r7_check_len_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len <= TOTAL_CHK);

  a_r7_check_len_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rfd_o) |-> run_len == TOTAL_CHK);
endmodule

bind rs_enc_mc rs_enc_mc_chk #(.TOTAL_CHK(TOTAL_CHK)) i_chk (.*);

// File: tb/test_rs_enc_mc.sv
`timescale 1ns/1ps
module test_rs_enc_mc;
  localparam int NCH = 8, KI = 239, NC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, start = 1'b0, nd = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic valid, rfd, rffd;

  always #10 clk = ~clk;

  rs_enc_mc i_rs_enc_mc (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .start_i(start), .nd_i(nd),
    .data_i(din), .data_o(dout), .valid_o(valid), .rfd_o(rfd), .rffd_o(rffd)
  );

  int tests = 0, fails = 0;
  string scen = "R10";

  // reference model state
  int  m_pos = 0;
  bit  m_busy = 0, m_chk = 0;
  bit  e_valid = 0;
  int  e_data = 0;
  bit  e_is_chk = 0;
  int  info [NCH][KI];
  int  chkq [$];
  int  gdesc [NC+1];

  function automatic int gmul(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) p ^= a;
      a = a << 1;
      if (a & 'h100) a ^= 'h11D;
    end
    return p;
  endfunction

  function automatic void make_gen();
    int asc [NC+1];
    int r = 1;
    foreach (asc[i]) asc[i] = 0;
    asc[0] = 1;
    for (int i = 0; i < NC; i++) begin
      int nw [NC+1];
      foreach (nw[j]) nw[j] = gmul(asc[j], r) ^ ((j > 0) ? asc[j-1] : 0);
      asc = nw;
      r = gmul(r, 2);
    end
    for (int j = 0; j <= NC; j++) gdesc[j] = asc[NC-j];
  endfunction

  // long division; returns check symbols highest degree first
  function automatic void build_checks();
    int par [NCH][NC];
    for (int c = 0; c < NCH; c++) begin
      int m [KI+NC];
      foreach (m[i]) m[i] = (i < KI) ? info[c][i] : 0;
      for (int i = 0; i < KI; i++) begin
        int cf = m[i];
        if (cf != 0)
          for (int j = 1; j <= NC; j++) m[i+j] ^= gmul(cf, gdesc[j]);
      end
      for (int p = 0; p < NC; p++) par[c][p] = m[KI+p];
    end
    chkq.delete();
    for (int p = 0; p < NC; p++)
      for (int c = 0; c < NCH; c++) chkq.push_back(par[c][p]);
  endfunction

  task automatic check_eq(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t", tag, scen, what, act, exp, $time);
    end
  endtask

  // one clock: compare at negedge, drive, step model on posedge
  task automatic cycle(bit c, bit s, bit n, int d);
    check_eq("R7", "rfd_o", int'(rfd), int'(!m_chk));
    check_eq("R8", "rffd_o", int'(rffd), int'(!m_busy));
    check_eq(e_is_chk ? "R4" : "R3", "valid_o", int'(valid), int'(e_valid));
    if (e_valid)
      check_eq(e_is_chk ? "R1 R2 R4" : "R3", "data_o", int'(dout), e_data);
    ce = c; start = s; nd = n; din = 8'(d);
    @(posedge clk);
    if (c) begin
      if (n && !m_chk && (m_busy || s)) begin
        info[m_pos % NCH][m_pos / NCH] = d & 'hFF;
        e_valid = 1; e_data = d & 'hFF; e_is_chk = 0;
        m_busy = 1; m_pos++;
        if (m_pos == NCH*KI) begin
          build_checks();
          m_chk = 1;
        end
      end else if (m_chk) begin
        e_valid = 1; e_data = chkq.pop_front(); e_is_chk = 1;
        if (chkq.size() == 0) begin
          m_chk = 0; m_busy = 0; m_pos = 0;
        end
      end else begin
        e_valid = 0;
      end
    end
    @(negedge clk);
  endtask

  // mode 0: full rate random, 1: impulse with nd gaps, 2: ce holes, stray starts
  task automatic run_group(int mode);
    bit started = 0;
    while (!(started && !m_busy)) begin
      bit c = 1, n = 1, s;
      int d = $urandom & 'hFF;
      s = !m_busy;
      if (mode == 1) begin
        n = ($urandom % 3) != 0 || !m_busy;
        if (n) d = (m_pos >= NCH*(KI-1)) ? (m_pos % NCH) + 1 : 0;
        if (m_chk) n = $urandom % 2;
      end
      if (mode == 2) begin
        c = ($urandom % 4) != 0;
        if (m_busy) s = $urandom % 2;
      end
      cycle(c, s, n, d);
      if (m_busy) started = 1;
    end
  endtask

  initial begin
    make_gen();
    #5;
    @(negedge clk);
    // R10: reset state
    check_eq("R10", "valid_o", int'(valid), 0);
    check_eq("R10", "data_o", int'(dout), 0);
    check_eq("R10", "rfd_o", int'(rfd), 1);
    check_eq("R10", "rffd_o", int'(rffd), 1);
    @(negedge clk);
    rst_n = 1'b1;

    scen = "R5 idle";
    for (int i = 0; i < 10; i++) cycle(1, 0, 1, i + 3);
    cycle(0, 1, 1, 7);
    cycle(1, 1, 0, 7);

    scen = "R1 random";
    run_group(0);
    scen = "R2 R6 impulse";
    run_group(1);
    scen = "R9 ce holes";
    run_group(2);
    scen = "R8 back-to-back";
    run_group(0);
    run_group(0);
    scen = "R5 tail";
    for (int i = 0; i < 4; i++) cycle(1, 0, 1, 'h55);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule